// File: doc/BRIEF.md
# Programmable Skew Clock Output Generator

This block is the digital model of the output stage of a multi-output clock driver. It runs from a fast timing clock whose period is one skew unit (tU). A free-running phase counter marks out a reference period, and four output pairs each carry a copy of the reference clock. Each copy is shifted by a whole number of tU, divided down, or inverted, depending on that pair's control code.

Each pair is controlled by two three-level digits. A range digit sets how many tU make one output period. Pairs 1 and 2 offer nine fine skew steps. Pairs 3 and 4 offer coarser steps, and use the two extreme codes for divide or invert functions. Control and range changes are captured only at a reference-period boundary. All outputs are registered.

Level encoding for every digit: 2'b00 = LOW, 2'b01 = MID, 2'b10 = HIGH, and 2'b11 = undriven, which is read as MID. Pair n (1..4) takes its control from `pair_ctl[4n-1:4n-4]`, with the upper two bits as the first digit and the lower two bits as the second. It drives `clk_q[2n-1:2n-2]`.

Top module: `skew_clk_gen`

## Requirements
- R1: The range digit sets the period P: LOW gives 32 tU, MID gives 16 tU and HIGH gives 8 tU (defaults, with a base of 8). The phase counter counts 0..P-1 and then wraps, and the wrap is the reference-period boundary.
- R2: For pairs 1 and 2, the codes LL, LM, LH, ML, MM, MH, HL, HM, HH select skews of -4, -3, -2, -1, 0, +1, +2, +3, +4 tU.
- R3: For pairs 3 and 4, the codes LM, LH, ML, MM, MH, HL, HM select skews of -6, -4, -2, 0, +2, +4, +6 tU.
- R4: Pair 3 with LL divides by 2, and with HH divides by 4. Reference periods are counted from reset starting at 0. The divide-by-2 output is high during even-numbered periods. The divide-by-4 output is high during periods whose count mod 4 is 0 or 1.
- R5: Pair 4 follows the R3 and R4 rules, except that HH gives the zero-skew waveform inverted.
- R6: A digit coded 2'b11 behaves exactly as MID, for both the range and the pair controls.
- R7: The two outputs of a pair are always equal.
- R8: The range and control inputs are sampled during reset and at each reference-period boundary, and are ignored at all other times.
- R9: While reset is high, the phase counter and the period counter clear and every output is low.
- R10: A skewed output is high when (p - s) mod P < P/2, where p is the phase and s is the skew. Outputs are registered, so the value for phase p appears one cycle after the counter holds p. For this reason, the zero-skew outputs are high in the first cycle after the first clock edge with reset low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock, one period per tU |
| rst | input | 1 | Synchronous active-high reset |
| range_code | input | 2 | Range digit selecting the output period |
| pair_ctl | input | 16 | Two control digits per pair, pair 1 in the low nibble |
| clk_q | output | 8 | Two outputs per pair, pair 1 in bits 1:0 |

## Verification
Every output lags the phase counter by exactly one register. A control change therefore shows up one cycle after the first boundary that follows it, and the divided outputs move one cycle after the period count steps. The bench drives its inputs on falling edges. It runs its own cycle-level model of these latencies, which it updates on rising edges, and it compares every output on the falling edge that follows. The zero-skew rise just after reset release and the rising-edge spacing under each range are also checked explicitly.

// File: rtl/skew_gen_pkg.sv
package skew_gen_pkg;

  localparam int NPAIRS = 4;
  localparam int CTL_W  = 4 * NPAIRS;
  localparam int Q_W    = 2 * NPAIRS;

  typedef enum logic [1:0] {LVL_LO = 2'd0, LVL_MID = 2'd1, LVL_HI = 2'd2} lvl_e;
  typedef enum logic [1:0] {MD_SKEW, MD_DIV2, MD_DIV4, MD_INV} mode_e;
  typedef enum logic [1:0] {KIND_FINE, KIND_DIV4, KIND_INV} kind_e;

  typedef struct packed {
    mode_e              mode;
    logic signed [3:0]  skew;
  } pair_cfg_t;

  // undriven (2'b11) reads as MID
  function automatic lvl_e norm_lvl(input logic [1:0] c);
    return (c == 2'b11) ? LVL_MID : lvl_e'(c);
  endfunction

  function automatic int period_of(input lvl_e r, input int base);
    case (r)
      LVL_LO:  return base * 4;
      LVL_HI:  return base;
      default: return base * 2;
    endcase
  endfunction

  // 0 = LL ... 4 = MM ... 8 = HH
  function automatic int nine_index(input logic [3:0] nib);
    return int'(norm_lvl(nib[3:2])) * 3 + int'(norm_lvl(nib[1:0]));
  endfunction

  function automatic pair_cfg_t decode_pair(input kind_e k, input logic [3:0] nib);
    pair_cfg_t c;
    int        idx;
    idx    = nine_index(nib);
    c.mode = MD_SKEW;
    c.skew = 4'sd0;
    if (k == KIND_FINE) begin
      c.skew = 4'(idx - 4);
    end else if (idx == 0) begin
      c.mode = MD_DIV2;
    end else if (idx == 8) begin
      c.mode = (k == KIND_DIV4) ? MD_DIV4 : MD_INV;
    end else begin
      c.skew = 4'(2 * (idx - 4));
    end
    return c;
  endfunction

  function automatic logic nominal_level(input int ph, input int skew, input int period);
    int d;
    d = ph - skew;
    if (d < 0)            d = d + period;
    else if (d >= period) d = d - period;
    return (d < period / 2);
  endfunction

  function automatic kind_e kind_of_pair(input int i);
    if (i < 2)  return KIND_FINE;
    if (i == 2) return KIND_DIV4;
    return KIND_INV;
  endfunction

endpackage

// File: rtl/skew_phase_timer.sv
module skew_phase_timer
  import skew_gen_pkg::*;
#(
  parameter int BASE_TU = 8,
  parameter int PH_W    = 5,
  parameter int PER_W   = 6
)(
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       range_code,
  output logic [PH_W-1:0]  ph,
  output logic [PER_W-1:0] per_cur,
  output logic             period_end,
  output logic [1:0]       frame,
  output lvl_e             act_range
);

  assign per_cur    = PER_W'(period_of(act_range, BASE_TU));
  assign period_end = ({1'b0, ph} == per_cur - PER_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      ph        <= '0;
      frame     <= 2'd0;
      act_range <= norm_lvl(range_code);
    end else if (period_end) begin
      ph        <= '0;
      frame     <= frame + 2'd1;
      act_range <= norm_lvl(range_code);
    end else begin
      ph        <= ph + PH_W'(1);
    end
  end

endmodule

// File: rtl/skew_ctl_hold.sv
module skew_ctl_hold #(
  parameter int W = 16
)(
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst || load) q <= d;
  end

endmodule

// File: rtl/skew_pair_unit.sv
module skew_pair_unit
  import skew_gen_pkg::*;
#(
  parameter kind_e KIND  = KIND_FINE,
  parameter int    PH_W  = 5,
  parameter int    PER_W = 6
)(
  input  logic             clk,
  input  logic             rst,
  input  logic [PH_W-1:0]  ph,
  input  logic [PER_W-1:0] per_cur,
  input  logic [1:0]       frame,
  input  logic [3:0]       nib,
  output logic [1:0]       q_pair
);

  pair_cfg_t cfg;
  logic      lvl_next;

  assign cfg = decode_pair(KIND, nib);

  always_comb begin
    case (cfg.mode)
      MD_DIV2: lvl_next = ~frame[0];
      MD_DIV4: lvl_next = ~frame[1];
      MD_INV:  lvl_next = ~nominal_level(int'(ph), 0, int'(per_cur));
      default: lvl_next = nominal_level(int'(ph), int'($signed(cfg.skew)), int'(per_cur));
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) q_pair <= 2'b00;
    else     q_pair <= {2{lvl_next}};
  end

endmodule

// File: rtl/skew_clk_gen.sv
module skew_clk_gen
  import skew_gen_pkg::*;
#(
  parameter int BASE_TU = 8
)(
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       range_code,
  input  logic [CTL_W-1:0] pair_ctl,
  output logic [Q_W-1:0]   clk_q
);

  localparam int PH_W  = $clog2(4 * BASE_TU);
  localparam int PER_W = PH_W + 1;

  logic [PH_W-1:0]  ph;
  logic [PER_W-1:0] per_cur;
  logic             period_end;
  logic [1:0]       frame;
  lvl_e             act_range;
  logic [CTL_W-1:0] act_ctl;

  skew_phase_timer #(.BASE_TU(BASE_TU), .PH_W(PH_W), .PER_W(PER_W)) timer_i (
    .clk(clk), .rst(rst), .range_code(range_code), .ph(ph), .per_cur(per_cur),
    .period_end(period_end), .frame(frame), .act_range(act_range)
  );

  skew_ctl_hold #(.W(CTL_W)) hold_i (
    .clk(clk), .rst(rst), .load(period_end), .d(pair_ctl), .q(act_ctl)
  );

  for (genvar i = 0; i < NPAIRS; i++) begin : g_pair
    skew_pair_unit #(.KIND(kind_of_pair(i)), .PH_W(PH_W), .PER_W(PER_W)) unit_i (
      .clk(clk), .rst(rst), .ph(ph), .per_cur(per_cur), .frame(frame),
      .nib(act_ctl[4*i +: 4]), .q_pair(clk_q[2*i +: 2])
    );
  end

endmodule

// File: rtl/skew_gen_chk.sv
module skew_gen_chk
  import skew_gen_pkg::*;
#(
  parameter int BASE_TU = 8,
  parameter int PH_W    = 5,
  parameter int PER_W   = 6
)(
  input logic             clk,
  input logic             rst,
  input logic [PH_W-1:0]  ph,
  input logic [PER_W-1:0] per_cur,
  input logic             period_end,
  input logic [1:0]       frame,
  input lvl_e             act_range,
  input logic [Q_W-1:0]   clk_q
);

  a_r1_phase_in_range: assert property (@(posedge clk) disable iff (rst)
    {1'b0, ph} < per_cur);

  a_r1_period_legal: assert property (@(posedge clk) disable iff (rst)
    (per_cur == PER_W'(BASE_TU)) || (per_cur == PER_W'(2 * BASE_TU)) ||
    (per_cur == PER_W'(4 * BASE_TU)));

  a_r1_wrap_to_zero: assert property (@(posedge clk) disable iff (rst)
    period_end |=> (ph == '0));

  a_r7_pair_match: assert property (@(posedge clk) disable iff (rst)
    (clk_q & 8'h55) == ((clk_q >> 1) & 8'h55));

  a_r9_reset_low: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (clk_q == '0));

  a_r8_range_hold: assert property (@(posedge clk) disable iff (rst)
    (!$past(period_end) && !$past(rst)) |-> $stable(act_range));

  a_r4_frame_hold: assert property (@(posedge clk) disable iff (rst)
    (!$past(period_end) && !$past(rst)) |-> $stable(frame));

  a_r4_frame_step: assert property (@(posedge clk) disable iff (rst)
    ($past(period_end) && !$past(rst)) |-> (frame == $past(frame) + 2'd1));

endmodule

bind skew_clk_gen skew_gen_chk #(.BASE_TU(BASE_TU), .PH_W(PH_W), .PER_W(PER_W)) chk_i (
  .clk(clk), .rst(rst), .ph(ph), .per_cur(per_cur), .period_end(period_end),
  .frame(frame), .act_range(act_range), .clk_q(clk_q)
);

// File: tb/skew_clk_gen_tb_top.sv
module skew_clk_gen_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  range_code = 2'b01;
  logic [15:0] pair_ctl = 16'h5555;
  logic [7:0]  clk_q;

  int vectors = 0;
  int fails   = 0;
  bit done    = 0;

  // bench reference state
  int          m_ph = 0;
  int          m_fc = 0;
  int          m_per = 16;
  logic [15:0] m_ctl = 16'h5555;
  logic [7:0]  m_exp = 8'h00;

  always #(CLK_PERIOD/2) clk = ~clk;

  skew_clk_gen dut_i (.clk(clk), .rst(rst), .range_code(range_code),
                      .pair_ctl(pair_ctl), .clk_q(clk_q));

  function automatic int tb_period(input logic [1:0] r);
    case (r)
      2'b00:   return 32;
      2'b10:   return 8;
      default: return 16;
    endcase
  endfunction

  function automatic logic [1:0] tb_norm(input logic [1:0] d);
    return (d == 2'b11) ? 2'b01 : d;
  endfunction

  // skew in tU, or 100 = /2, 200 = /4, 300 = inverted
  function automatic int tb_sel(input int pair, input logic [3:0] nib);
    logic [3:0] k;
    k = {tb_norm(nib[3:2]), tb_norm(nib[1:0])};
    if (pair < 2) begin
      case (k)
        4'b0000: return -4;  4'b0001: return -3;  4'b0010: return -2;
        4'b0100: return -1;  4'b0101: return 0;   4'b0110: return 1;
        4'b1000: return 2;   4'b1001: return 3;   default: return 4;
      endcase
    end
    case (k)
      4'b0000: return 100;  4'b0001: return -6;  4'b0010: return -4;
      4'b0100: return -2;   4'b0101: return 0;   4'b0110: return 2;
      4'b1000: return 4;    4'b1001: return 6;
      default: return (pair == 2) ? 200 : 300;
    endcase
  endfunction

  function automatic logic [7:0] tb_expect(input int ph, input int fc, input int per,
                                           input logic [15:0] ctl);
    logic [7:0] e;
    logic       b;
    int         v;
    for (int p = 0; p < 4; p++) begin
      v = tb_sel(p, ctl[4*p +: 4]);
      if (v == 100)      b = (fc % 2) == 0;
      else if (v == 200) b = (fc % 4) < 2;
      else if (v == 300) b = !(ph < per / 2);
      else               b = ((ph - v + 4 * per) % per) < per / 2;
      e[2*p +: 2] = {b, b};
    end
    return e;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_ph = 0; m_fc = 0; m_per = tb_period(range_code); m_ctl = pair_ctl; m_exp = 8'h00;
    end else begin
      m_exp = tb_expect(m_ph, m_fc, m_per, m_ctl);
      if (m_ph == m_per - 1) begin
        m_ph = 0; m_fc = (m_fc + 1) % 4; m_per = tb_period(range_code); m_ctl = pair_ctl;
      end else begin
        m_ph = m_ph + 1;
      end
    end
  end

  task automatic check_val(input string tag, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: clk_q=%h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic run_cycles(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check_val(tag, clk_q, m_exp);
    end
    // R7: each pair's two outputs agree
    check_val("R7", clk_q & 8'h55, (clk_q >> 1) & 8'h55);
  endtask

  function automatic logic [3:0] nib_of(input int k);
    return {2'(k / 3), 2'(k % 3)};
  endfunction

  task automatic t_reset();
    @(negedge clk);
    rst = 1'b1; range_code = 2'b01; pair_ctl = 16'h5555;
    repeat (3) @(negedge clk);
    check_val("R9", clk_q, 8'h00);
    rst = 1'b0;
    @(negedge clk);
    check_val("R10", clk_q, 8'hFF);
    run_cycles(40, "R10");
  endtask

  task automatic t_fine();
    for (int k = 0; k < 9; k++) begin
      @(negedge clk);
      pair_ctl = {8'h55, nib_of(8 - k), nib_of(k)};
      run_cycles(48, "R2");
    end
  endtask

  task automatic t_coarse();
    for (int k = 1; k < 8; k++) begin
      @(negedge clk);
      pair_ctl = {nib_of(8 - k), nib_of(k), 8'h55};
      run_cycles(48, "R3");
    end
  endtask

  task automatic t_divide();
    @(negedge clk);
    pair_ctl = {4'h5, 4'h0, 8'h55};
    run_cycles(100, "R4");
    @(negedge clk);
    pair_ctl = {4'h5, 4'hA, 8'h55};
    run_cycles(130, "R4");
    @(negedge clk);
    pair_ctl = {4'h0, 4'h5, 8'h55};
    run_cycles(100, "R5");
    @(negedge clk);
    pair_ctl = {4'hA, 4'hA, 8'h55};
    run_cycles(60, "R5");
  endtask

  task automatic t_float();
    @(negedge clk);
    pair_ctl = 16'hDF7D; range_code = 2'b11;
    run_cycles(70, "R6");
    @(negedge clk);
    pair_ctl = 16'hFFFF;
    run_cycles(40, "R6");
  endtask

  task automatic t_range();
    logic [1:0] codes [3] = '{2'b00, 2'b01, 2'b10};
    int         per_exp [3] = '{32, 16, 8};
    int         c0, c1;
    logic       prev;
    for (int r = 0; r < 3; r++) begin
      @(negedge clk);
      range_code = codes[r]; pair_ctl = 16'h5555;
      run_cycles(80, "R1");
      c0 = 0; c1 = 0; prev = clk_q[0];
      for (int i = 1; i < 100 && c1 == 0; i++) begin
        @(negedge clk);
        if (clk_q[0] && !prev) begin
          if (c0 == 0) c0 = i; else c1 = i;
        end
        prev = clk_q[0];
      end
      check_val("R1", 8'(c1 - c0), 8'(per_exp[r]));
    end
  endtask

  task automatic t_midchange();
    @(negedge clk);
    range_code = 2'b01; pair_ctl = 16'h5555;
    run_cycles(37, "R8");
    pair_ctl = 16'h0888; range_code = 2'b10;
    run_cycles(5, "R8");
    pair_ctl = 16'h5555; range_code = 2'b01;
    run_cycles(60, "R8");
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_fine();
    t_coarse();
    t_divide();
    t_float();
    t_range();
    t_midchange();
    t_reset();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule